// File: doc/BRIEF.md
# Cache-Line Zeroing Engine

This block clears one cache line of memory in answer to a single zero-line command. It takes the command address and rounds it down to the start of the line that contains it. In its first busy cycle it checks the load-reservation address it is given. If that address lies in the same line, it pulses a strobe that tells the reservation logic to drop the reservation. It then writes the whole line as a run of 64-bit zero beats at rising addresses. Each beat waits for its own acknowledge.

The line size is normally the `LINE_BYTES` parameter. It falls to `SHORT_BYTES` when the 2-bit size-mode input equals `SHORT_CODE` and the command's opcode selector bit is clear. A command is taken through a valid/ready handshake, and only while the engine is idle. After the final beat is acknowledged, `done` pulses for one cycle. Address translation, coherence and the cache arrays sit outside this block.

Top module: `line_zero_engine`

## Requirements
- R1: `cmd_ready` is 1 only while the engine is idle. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` is 0 from the cycle after acceptance until the cycle after `done`.
- R2: The first write beat goes to the command address with the low log2(line size) bits cleared.
- R3: Beat k goes to base + 8*k, and every beat carries all-zero 64-bit data.
- R4: With the size-mode input not equal to 1, a line is `LINE_BYTES`/8 beats long (16 by default).
- R5: With the size-mode input equal to 1 and `cmd_line_sel` equal to 0, the line is `SHORT_BYTES` (32 by default). It is aligned to that size and takes 4 beats.
- R6: When `cmd_line_sel` is 1, the normal line size applies whatever the size-mode input holds.
- R7: In the cycle after acceptance, `resv_clear` is 1 exactly when `resv_addr` with the line offset bits cleared equals the aligned base. That cycle has no write beat, and the strobe lasts one cycle.
- R8: Once `wr_valid` is 1, it stays 1 and `wr_addr` stays unchanged until `wr_ack` is seen.
- R9: `done` is 1 for exactly one cycle, the cycle after the last beat's acknowledge. It is 0 at all other times.
- R10: After a synchronous active-low reset, including one in the middle of a line, `cmd_ready`=1, `wr_valid`=0, `resv_clear`=0 and `done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Zero-line command present |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_addr | input | ADDR_W | Any byte address inside the target line |
| cmd_line_sel | input | 1 | Opcode selector bit; 1 forces the normal line size |
| cfg_size_mode | input | 2 | Size-mode field; value 1 enables the short line |
| resv_addr | input | ADDR_W | Current load-reservation address |
| resv_clear | output | 1 | One-cycle strobe: invalidate the reservation |
| wr_valid | output | 1 | Write beat present |
| wr_addr | output | ADDR_W | Byte address of the beat |
| wr_data | output | 64 | Beat data (zero) |
| wr_ack | input | 1 | Memory takes the current beat |
| done | output | 1 | One-cycle pulse after the last beat is acknowledged |

## Verification
The hardest case to reach is a reservation that sits close to the aligned base but not in the same line. One example is a reservation in the first 32 bytes of a 128-byte line while a short-line command targets the second 32-byte block. In that case the compare must use the short mask, and the strobe must stay low. The vector table sets up this case, its opposite in the top line of the address space, and the case where the selector bit forces the long line. Acknowledge delays vary from vector to vector so that the address-hold rule is exercised. A directed test also resets the engine while beats are still outstanding.

// File: rtl/lz_pkg.sv
// Package: shared types and constants for the line zeroing engine.
// Assumes 64-bit write beats.
package lz_pkg;
    localparam int BEAT_BYTES = 8;
    localparam int DATA_W     = 64;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_WRITE = 2'd2,
        ST_DONE  = 2'd3
    } lz_state_e;
endpackage

// File: rtl/lz_size_sel.sv
// Line size selector. From the command's selector bit and the size-mode
// field it works out the byte offset mask of the line and the index of
// the last beat. Assumes both sizes are powers of two and at least one beat.
module lz_size_sel #(
    parameter int          ADDR_W      = 32,
    parameter int          LINE_BYTES  = 128,
    parameter int          SHORT_BYTES = 32,
    parameter logic [1:0]  SHORT_CODE  = 2'd1,
    localparam int         LONG_BEATS  = LINE_BYTES / lz_pkg::BEAT_BYTES,
    localparam int         IDX_W       = (LONG_BEATS > 1) ? $clog2(LONG_BEATS) : 1
) (
    input  logic              line_sel,
    input  logic [1:0]        size_mode,
    output logic [ADDR_W-1:0] ofs_mask,
    output logic [IDX_W-1:0]  last_idx
);
    localparam int SHORT_BEATS = SHORT_BYTES / lz_pkg::BEAT_BYTES;

    logic use_short;

    // Pick the short-line rule only when the parameters make it a real choice.
    generate
        if (SHORT_BYTES < LINE_BYTES) begin : g_dual
            assign use_short = (size_mode == SHORT_CODE) && !line_sel;
        end else begin : g_single
            logic unused_sel;
            assign unused_sel = line_sel ^ (^size_mode);
            assign use_short  = 1'b0;
        end
    endgenerate

    // Mask of offset bits and index of the final beat for the chosen size.
    always_comb begin
        if (use_short) begin
            ofs_mask = ADDR_W'(SHORT_BYTES - 1);
            last_idx = IDX_W'(SHORT_BEATS - 1);
        end else begin
            ofs_mask = ADDR_W'(LINE_BYTES - 1);
            last_idx = IDX_W'(LONG_BEATS - 1);
        end
    end
endmodule

// File: rtl/lz_resv_cmp.sv
// Reservation line compare. Reports whether the reservation address falls
// in the line that starts at the aligned base. Assumes the base is already
// aligned with the same mask.
module lz_resv_cmp #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] resv_addr,
    input  logic [ADDR_W-1:0] line_base,
    input  logic [ADDR_W-1:0] ofs_mask,
    output logic              same_line
);
    // Clear the offset bits of the reservation and compare line numbers.
    always_comb begin
        same_line = ((resv_addr & ~ofs_mask) == line_base);
    end
endmodule

// File: rtl/lz_beat_seq.sv
// Beat sequencer. Holds the aligned base and a beat index. It gives the
// address of the current beat and flags the final one. It steps only on
// advance. Assumes load and advance are never 1 together.
module lz_beat_seq #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base_in,
    input  logic [IDX_W-1:0]  last_in,
    input  logic              advance,
    output logic [ADDR_W-1:0] line_base,
    output logic [ADDR_W-1:0] beat_addr,
    output logic              is_last
);
    localparam int SHIFT = $clog2(lz_pkg::BEAT_BYTES);

    logic [ADDR_W-1:0] base_q;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  last_q;

    // Capture a new line on load; step the index on each accepted beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            idx_q  <= '0;
            last_q <= '0;
        end else if (load) begin
            base_q <= base_in;
            idx_q  <= '0;
            last_q <= last_in;
        end else if (advance) begin
            idx_q  <= idx_q + 1'b1;
        end
    end

    // Beat address is the base plus eight bytes per completed beat.
    always_comb begin
        line_base = base_q;
        beat_addr = base_q + (ADDR_W'(idx_q) << SHIFT);
        is_last   = (idx_q == last_q);
    end
endmodule

// File: rtl/line_zero_engine.sv
// Line zeroing engine top. Takes one command when idle, aligns it to the
// selected line size, checks the reservation in the first busy cycle, then
// issues zero beats that each wait for an acknowledge, and pulses done.
// Assumes wr_ack is only meaningful while wr_valid is 1.
module line_zero_engine #(
    parameter int          ADDR_W      = 32,
    parameter int          LINE_BYTES  = 128,
    parameter int          SHORT_BYTES = 32,
    parameter logic [1:0]  SHORT_CODE  = 2'd1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cmd_valid,
    output logic                      cmd_ready,
    input  logic [ADDR_W-1:0]         cmd_addr,
    input  logic                      cmd_line_sel,
    input  logic [1:0]                cfg_size_mode,
    input  logic [ADDR_W-1:0]         resv_addr,
    output logic                      resv_clear,
    output logic                      wr_valid,
    output logic [ADDR_W-1:0]         wr_addr,
    output logic [lz_pkg::DATA_W-1:0] wr_data,
    input  logic                      wr_ack,
    output logic                      done
);
    import lz_pkg::*;

    localparam int LONG_BEATS = LINE_BYTES / BEAT_BYTES;
    localparam int IDX_W      = (LONG_BEATS > 1) ? $clog2(LONG_BEATS) : 1;

    lz_state_e         state_q, state_d;
    logic [ADDR_W-1:0] cmd_mask;
    logic [IDX_W-1:0]  cmd_last;
    logic [ADDR_W-1:0] mask_q;
    logic [ADDR_W-1:0] line_base;
    logic [ADDR_W-1:0] beat_addr;
    logic              is_last;
    logic              same_line;
    logic              accept;
    logic              beat_done;

    lz_size_sel #(
        .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES),
        .SHORT_BYTES(SHORT_BYTES), .SHORT_CODE(SHORT_CODE)
    ) u_size (
        .line_sel (cmd_line_sel),
        .size_mode(cfg_size_mode),
        .ofs_mask (cmd_mask),
        .last_idx (cmd_last)
    );

    lz_beat_seq #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .base_in  (cmd_addr & ~cmd_mask),
        .last_in  (cmd_last),
        .advance  (beat_done),
        .line_base(line_base),
        .beat_addr(beat_addr),
        .is_last  (is_last)
    );

    lz_resv_cmp #(.ADDR_W(ADDR_W)) u_resv (
        .resv_addr(resv_addr),
        .line_base(line_base),
        .ofs_mask (mask_q),
        .same_line(same_line)
    );

    // Handshake terms shared by the state machine and the sequencer.
    always_comb begin
        accept    = cmd_valid && (state_q == ST_IDLE);
        beat_done = (state_q == ST_WRITE) && wr_ack;
    end

    // Next-state choice: idle, reservation check, write beats, done pulse.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cmd_valid) state_d = ST_CHECK;
            ST_CHECK: state_d = ST_WRITE;
            ST_WRITE: if (wr_ack && is_last) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register and captured line mask for the reservation compare.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mask_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) mask_q <= cmd_mask;
        end
    end

    // Output decode from the current state.
    always_comb begin
        cmd_ready  = (state_q == ST_IDLE);
        resv_clear = (state_q == ST_CHECK) && same_line;
        wr_valid   = (state_q == ST_WRITE);
        wr_addr    = beat_addr;
        wr_data    = '0;
        done       = (state_q == ST_DONE);
    end

    // R1: never ready while a beat is outstanding.
    p_busy_not_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !cmd_ready);

    // R8: a stalled beat keeps its address and stays valid.
    p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ack) |=> (wr_valid && $stable(wr_addr)));

    // R7: the reservation strobe comes before any beat and lasts one cycle.
    p_clear_no_beat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        resv_clear |-> !wr_valid);
    p_clear_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        resv_clear |=> !resv_clear);

    // R9: done is a single cycle, right after an acknowledged beat.
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_after_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(wr_valid && wr_ack));

    // R2: a beat address never leaves the line of the captured base.
    p_in_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> ((wr_addr & ~mask_q) == line_base));
endmodule

// File: tb/tb_line_zero_engine.sv
module tb_line_zero_engine;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [AW-1:0] cmd_addr = '0;
    logic          cmd_line_sel = 1'b0;
    logic [1:0]    cfg_size_mode = 2'd0;
    logic [AW-1:0] resv_addr = '1;
    logic          resv_clear;
    logic          wr_valid;
    logic [AW-1:0] wr_addr;
    logic [63:0]   wr_data;
    logic          wr_ack = 1'b0;
    logic          done;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #10 clk = ~clk;   // 50 MHz

    line_zero_engine dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_line_sel(cmd_line_sel), .cfg_size_mode(cfg_size_mode),
        .resv_addr(resv_addr), .resv_clear(resv_clear), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack), .done(done)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic        sel;
        logic [1:0]  mode;
        logic [31:0] resv;
        logic [1:0]  wait_n;
        logic [31:0] exp_base;
        logic [4:0]  exp_beats;
        logic        exp_clear;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        // R4 long line, reservation in the line
        '{32'h0000_1234, 1'b0, 2'd0, 32'h0000_1200, 2'd0, 32'h0000_1200, 5'd16, 1'b1},
        // R5 short line; reservation in the previous 32-byte block
        '{32'h0000_1234, 1'b0, 2'd1, 32'h0000_1200, 2'd0, 32'h0000_1220, 5'd4,  1'b0},
        // R6 selector bit forces long line; reservation in the next line
        '{32'h0000_1234, 1'b1, 2'd1, 32'h0000_12FF, 2'd1, 32'h0000_1200, 5'd16, 1'b0},
        // R4 top offset of line, slow acks
        '{32'h8000_007F, 1'b0, 2'd2, 32'h8000_0000, 2'd2, 32'h8000_0000, 5'd16, 1'b1},
        // R5 short line at the top of the address space
        '{32'hFFFF_FFE8, 1'b0, 2'd1, 32'hFFFF_FFFF, 2'd1, 32'hFFFF_FFE0, 5'd4,  1'b1},
        // R4 mode 3, no match
        '{32'h0000_0040, 1'b0, 2'd3, 32'hFFFF_FFFF, 2'd3, 32'h0000_0000, 5'd16, 1'b0}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 100000);
            finish_up();
        end
    end

    task automatic run_cmd(input vec_t t);
        string size_tag;
        size_tag = (t.exp_beats == 5'd4) ? "R5" : ((t.mode == 2'd1) ? "R6" : "R4");
        chk("R1 ready idle", cmd_ready, 1);
        cmd_valid = 1'b1; cmd_addr = t.addr; cmd_line_sel = t.sel;
        cfg_size_mode = t.mode; resv_addr = t.resv;
        @(posedge clk); @(negedge clk);
        cmd_valid = 1'b0;
        chk("R7 clear strobe", resv_clear, t.exp_clear);
        chk("R7 no beat in check cycle", wr_valid, 0);
        chk("R1 busy not ready", cmd_ready, 0);
        @(posedge clk); @(negedge clk);
        chk("R7 strobe one cycle", resv_clear, 0);
        for (int i = 0; i < t.exp_beats; i++) begin
            for (int w = 0; w < t.wait_n; w++) begin
                chk("R8 valid held", wr_valid, 1);
                chk("R8 addr held", wr_addr, t.exp_base + 32'(8 * i));
                @(posedge clk); @(negedge clk);
            end
            chk(i == 0 ? "R2 aligned base" : "R3 beat addr", wr_valid ? wr_addr : 32'hDEAD_BEEF,
                t.exp_base + 32'(8 * i));
            chk("R3 zero data", wr_data, 0);
            chk("R9 no early done", done, 0);
            wr_ack = 1'b1;
            @(posedge clk); @(negedge clk);
            wr_ack = 1'b0;
        end
        chk({size_tag, " beat count"}, wr_valid, 0);
        chk("R9 done after last ack", done, 1);
        @(posedge clk); @(negedge clk);
        chk("R9 done one cycle", done, 0);
        chk("R1 ready after done", cmd_ready, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        chk("R10 ready", cmd_ready, 1);
        chk("R10 wr_valid", wr_valid, 0);
        chk("R10 done", done, 0);
        chk("R10 resv_clear", resv_clear, 0);

        for (int v = 0; v < NV; v++) run_cmd(VECS[v]);

        // R10 reset in the middle of a line
        cmd_valid = 1'b1; cmd_addr = 32'h0000_2000; cmd_line_sel = 1'b0;
        cfg_size_mode = 2'd0; resv_addr = '1;
        @(posedge clk); @(negedge clk);
        cmd_valid = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R10 setup beat", wr_valid, 1);
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R10 mid-line wr_valid", wr_valid, 0);
        chk("R10 mid-line ready", cmd_ready, 1);
        chk("R10 mid-line done", done, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 back-to-back after a reset: engine takes a fresh short command
        run_cmd('{32'h0000_3010, 1'b0, 2'd1, 32'h0000_3000, 2'd0, 32'h0000_3000, 5'd4, 1'b1});

        finish_up();
    end
endmodule